// File: doc/BRIEF.md
# Fully Associative Translation Cache with LRU Replacement

This block caches recent virtual-to-physical page translations. Each entry stores a valid flag, a virtual page number that serves as the search key, and the physical page number it maps to. A lookup compares the requested virtual page against every entry in parallel. It returns a hit flag and the physical page in the same cycle, so the lookup path is purely combinational.

A page-walk engine writes a new mapping through the fill port once a walk completes. The replacement choice favours any empty slot, lowest index first. When every slot is occupied, the entry that was used least recently is replaced. Both a lookup hit and a fill count as a use. The chosen slot is visible on `repl_way`.

Two controls remove entries. A flush pulse empties the whole cache; it is meant for the moment the translation-table base changes. A single-page invalidate removes only the entry whose key equals the supplied virtual page.

Top module: `tlb`

## Requirements
- R1: A lookup is combinational: `lk_hit` and `lk_ppn` reflect `lk_vpn` in the same cycle, with no clock edge in between.
- R2: After reset every entry is invalid and `repl_way` is 0.
- R3: `lk_hit` is 1 only when a valid entry holds a key equal to `lk_vpn`. On an empty cache, virtual page 0x00000 misses even though the stored keys reset to zero.
- R4: While any entry is invalid, `repl_way` names the lowest-indexed invalid entry. Successive fills into an empty cache therefore land in entries 0, 1, 2, 3 in turn.
- R5: When all entries are valid, a fill with a new key overwrites the least recently used entry. `repl_way` then moves to the next-oldest entry.
- R6: A lookup hit (`lk_valid`=1) and a fill each make the touched entry the most recently used. Recency is kept as a 2-bit age per entry.
- R7: A `flush` pulse clears the valid flag of every entry.
- R8: `inv_valid` with `inv_vpn` clears only the valid entry whose key matches. A key that matches no entry changes nothing.
- R9: A fill whose key already exists in a valid entry updates that entry's physical page in place and allocates no new slot.
- R10: When `flush` and `fill_valid` are high in the same cycle, the flush wins and the fill is discarded.
- R11: Fills, invalidations and flushes take effect at the next rising clock edge. A lookup in the same cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request; a hit updates recency |
| lk_vpn | input | 20 | Virtual page to translate |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_ppn | output | 20 | Physical page of the matching entry (0 on miss) |
| fill_valid | input | 1 | Write a new mapping |
| fill_vpn | input | 20 | Virtual page of the new mapping |
| fill_ppn | input | 20 | Physical page of the new mapping |
| flush | input | 1 | Invalidate all entries |
| inv_valid | input | 1 | Invalidate a single page |
| inv_vpn | input | 20 | Virtual page to invalidate |
| repl_way | output | 2 | Entry the next new-key fill will occupy |

## Verification
The bench builds the block with its default parameters: four entries, 20-bit virtual and physical pages, and a 2-bit age. With only four slots, a handful of fills is enough to move the cache through empty, partly full and full states.

That small size puts the interesting cases within reach of short directed sequences:
- every age ordering that decides the victim;
- refreshing a slot by a hit;
- an in-place update;
- a hole punched by invalidation, which must be refilled before any valid entry is evicted;
- a flush that coincides with a fill.

// File: rtl/tlb_pkg.sv
// Package: shared defaults for the translation cache.
// Assumes: consumers take these as parameter defaults only.
package tlb_pkg;
    localparam int unsigned TLB_ENTRIES_DEF = 4;
    localparam int unsigned TLB_VPN_W_DEF   = 20;
    localparam int unsigned TLB_PPN_W_DEF   = 20;
endpackage

// File: rtl/tlb_cam.sv
// Module: tlb_cam
// Parallel key compare over all entries, qualified by the valid flags.
// Reports the match vector, whether any entry matched, and the index of
// the lowest matching entry.
// Assumes: the caller keeps keys unique among valid entries, so at most
// one entry matches.
module tlb_cam #(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned KEY_W   = 20,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [KEY_W-1:0]              key,
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][KEY_W-1:0] keys,
    output logic [ENTRIES-1:0]            match,
    output logic                          any,
    output logic [IDX_W-1:0]              idx
);
    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (keys[g] == key);
    end

    assign any = |match;

    // Priority encode: the lowest matching index wins.
    always_comb begin
        idx = '0;
        for (int k = ENTRIES - 1; k >= 0; k--) begin
            if (match[k]) idx = IDX_W'(k);
        end
    end
endmodule

// File: rtl/tlb_lru.sv
// Module: tlb_lru
// Keeps one age per entry (0 = most recent, ENTRIES-1 = oldest) and
// selects a victim. The victim is the lowest-indexed invalid entry if
// one exists, otherwise the entry whose age is ENTRIES-1.
// Assumes: ages always form a permutation. Reset loads one, and every
// touch preserves it.
module tlb_lru #(
    parameter int unsigned ENTRIES = 4,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid,
    output logic [IDX_W-1:0]   victim
);
    logic [ENTRIES-1:0][IDX_W-1:0] age_q;
    logic [IDX_W-1:0]              touched_age;

    assign touched_age = age_q[touch_idx];

    // Per-entry age update: the touched entry becomes youngest, and
    // entries younger than it age by one.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_age
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age_q[g] <= IDX_W'(ENTRIES - 1 - g);
            end else if (touch) begin
                if (touch_idx == IDX_W'(g)) begin
                    age_q[g] <= '0;
                end else if (age_q[g] < touched_age) begin
                    age_q[g] <= age_q[g] + 1'b1;
                end
            end
        end
    end

    // Victim select: the first invalid entry, else the oldest.
    always_comb begin
        logic found;
        found  = 1'b0;
        victim = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (!found && !valid[k]) begin
                victim = IDX_W'(k);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int k = 0; k < ENTRIES; k++) begin
                if (age_q[k] == IDX_W'(ENTRIES - 1)) victim = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/tlb.sv
// Module: tlb (top)
// Fully associative translation cache with LRU replacement, a flush of
// all entries, and single-page invalidation. Lookup is combinational.
// Fill, invalidate and flush update state on the next edge.
// Assumes: one fill per cycle. When a fill and a lookup hit arrive
// together, the fill decides the recency update.
module tlb
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = TLB_ENTRIES_DEF,
    parameter int unsigned VPN_W   = TLB_VPN_W_DEF,
    parameter int unsigned PPN_W   = TLB_PPN_W_DEF,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             flush,
    input  logic             inv_valid,
    input  logic [VPN_W-1:0] inv_vpn,
    output logic [IDX_W-1:0] repl_way
);
    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0][VPN_W-1:0] key_q;
    logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;

    logic [ENTRIES-1:0] lk_match, fl_match, iv_match;
    logic               fl_any, iv_any;
    logic [IDX_W-1:0]   lk_idx, fl_idx, iv_idx;
    logic [IDX_W-1:0]   victim, fill_tgt;
    logic               touch;
    logic [IDX_W-1:0]   touch_idx;

    // Compare path for lookups.
    tlb_cam #(.ENTRIES(ENTRIES), .KEY_W(VPN_W)) u_cam_lk (
        .key(lk_vpn), .valid(valid_q), .keys(key_q),
        .match(lk_match), .any(lk_hit), .idx(lk_idx)
    );

    // Compare path for fills, to detect an existing key.
    tlb_cam #(.ENTRIES(ENTRIES), .KEY_W(VPN_W)) u_cam_fl (
        .key(fill_vpn), .valid(valid_q), .keys(key_q),
        .match(fl_match), .any(fl_any), .idx(fl_idx)
    );

    // Compare path for single-page invalidation.
    tlb_cam #(.ENTRIES(ENTRIES), .KEY_W(VPN_W)) u_cam_iv (
        .key(inv_vpn), .valid(valid_q), .keys(key_q),
        .match(iv_match), .any(iv_any), .idx(iv_idx)
    );

    // Recency tracking and victim choice.
    tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(touch_idx),
        .valid(valid_q), .victim(victim)
    );

    // Output mux: the physical page of the hitting entry, zero on a miss.
    assign lk_ppn = lk_hit ? ppn_q[lk_idx] : '0;

    // Fill target: the existing entry if the key is present, else the victim.
    assign fill_tgt = fl_any ? fl_idx : victim;
    assign repl_way = victim;

    // Recency touch: a fill takes precedence over a lookup hit; a flush
    // suppresses both.
    assign touch     = !flush && (fill_valid || (lk_valid && lk_hit));
    assign touch_idx = fill_valid ? fill_tgt : lk_idx;

    // Entry storage: the flush has priority, then the invalidate, then
    // the fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            key_q   <= '0;
            ppn_q   <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else begin
            if (inv_valid && iv_any) valid_q[iv_idx] <= 1'b0;
            if (fill_valid) begin
                valid_q[fill_tgt] <= 1'b1;
                key_q[fill_tgt]   <= fill_vpn;
                ppn_q[fill_tgt]   <= fill_ppn;
            end
        end
    end
endmodule

// File: rtl/tlb_chk.sv
// Module: tlb_chk
// Property checker bound to every tlb instance. It observes the ports
// and the valid vector.
// Assumes: synchronous active-low reset on rst_n.
module tlb_chk #(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_hit,
    input logic               fill_valid,
    input logic               flush,
    input logic               inv_valid,
    input logic [IDX_W-1:0]   repl_way,
    input logic [ENTRIES-1:0] valid_q
);
    // R2: the first cycle out of reset has an empty cache and pointer 0.
    assert_reset_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0 && repl_way == '0));

    // R3: a hit needs at least one valid entry.
    assert_hit_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (valid_q != '0));

    // R4: while a hole exists, the pointer names an invalid entry.
    assert_repl_hole_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q != '1) |-> !valid_q[repl_way]);

    // R7: a flush empties the cache at the next edge.
    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));

    // R8: an invalidate alone removes at most one entry.
    assert_inval_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !fill_valid && !flush) |=>
            ($countones($past(valid_q)) <= $countones(valid_q) + 1));

    // R5: a fill alone never lowers the number of valid entries.
    assert_fill_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !inv_valid && !flush) |=>
            ($countones(valid_q) >= $countones($past(valid_q))));
endmodule

bind tlb tlb_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_tlb_chk (
    .clk(clk), .rst_n(rst_n), .lk_hit(lk_hit), .fill_valid(fill_valid),
    .flush(flush), .inv_valid(inv_valid), .repl_way(repl_way),
    .valid_q(valid_q)
);

// File: tb/tlb_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected lookup results into
// queues, and a negedge monitor pops and compares them.
module tlb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_hit;
    logic [19:0] lk_ppn;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic        flush = 1'b0;
    logic        inv_valid = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic [1:0]  repl_way;

    int checks = 0;
    int failures = 0;

    bit          exp_hit_q[$];
    logic [19:0] exp_ppn_q[$];
    string       exp_req_q[$];

    always #2.5 clk = ~clk;

    tlb u_tlb (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .fill_valid(fill_valid),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .flush(flush),
        .inv_valid(inv_valid), .inv_vpn(inv_vpn), .repl_way(repl_way)
    );

    // Monitor: compare each lookup, mid-cycle, against the scoreboard head.
    always @(negedge clk) begin
        if (lk_valid && exp_hit_q.size() > 0) begin
            bit          eh;
            logic [19:0] ep;
            string       r;
            eh = exp_hit_q.pop_front();
            ep = exp_ppn_q.pop_front();
            r  = exp_req_q.pop_front();
            checks++;
            if (lk_hit !== eh || (eh && lk_ppn !== ep)) begin
                failures++;
                $display("FAIL %s vpn=%h: hit=%0b ppn=%h expected hit=%0b ppn=%h",
                         r, lk_vpn, lk_hit, lk_ppn, eh, ep);
            end
        end
    end

    // Driver: one cycle carrying any mix of lookup, fill, invalidate and flush.
    task automatic op(input bit lk, input logic [19:0] lv, input bit eh,
                      input logic [19:0] ep, input string r,
                      input bit fl, input logic [19:0] fv, input logic [19:0] fp,
                      input bit iv, input logic [19:0] ivp, input bit fsh);
        @(posedge clk); #1;
        lk_valid = lk;  lk_vpn = lv;
        fill_valid = fl; fill_vpn = fv; fill_ppn = fp;
        inv_valid = iv; inv_vpn = ivp; flush = fsh;
        if (lk) begin
            exp_hit_q.push_back(eh);
            exp_ppn_q.push_back(ep);
            exp_req_q.push_back(r);
        end
        @(posedge clk); #1;
        lk_valid = 1'b0; fill_valid = 1'b0; inv_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic look(input logic [19:0] v, input bit eh, input logic [19:0] ep,
                        input string r);
        op(1'b1, v, eh, ep, r, 1'b0, '0, '0, 1'b0, '0, 1'b0);
    endtask

    task automatic fill(input logic [19:0] v, input logic [19:0] p);
        op(1'b0, '0, 1'b0, '0, "", 1'b1, v, p, 1'b0, '0, 1'b0);
    endtask

    task automatic chk_repl(input logic [1:0] e, input string r);
        @(negedge clk);
        checks++;
        if (repl_way !== e) begin
            failures++;
            $display("FAIL %s repl_way=%0d expected %0d", r, repl_way, e);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #500000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_repl(2'd0, "R2 reset pointer");
        look(20'h00000, 1'b0, '0, "R3 zero key on empty");
        // R11: a lookup in the same cycle as the fill still misses.
        op(1'b1, 20'h00003, 1'b0, '0, "R11 same-cycle fill",
           1'b1, 20'h00003, 20'h00005, 1'b0, '0, 1'b0);
        chk_repl(2'd1, "R4 pointer after first fill");
        look(20'h00003, 1'b1, 20'h00005, "R1 combinational hit");
        look(20'h00000, 1'b0, '0, "R3 zero key partial");
        look(20'h00007, 1'b0, '0, "R3 absent key");
        fill(20'h00007, 20'h00009);
        chk_repl(2'd2, "R4 pointer after second fill");
        fill(20'h00009, 20'h00001);
        chk_repl(2'd3, "R4 pointer after third fill");
        fill(20'h0000B, 20'h00003);
        chk_repl(2'd0, "R5 oldest is entry 0");
        fill(20'h0000D, 20'h0000A);
        chk_repl(2'd1, "R5 pointer after eviction");
        look(20'h00003, 1'b0, '0, "R5 evicted key misses");
        look(20'h0000D, 1'b1, 20'h0000A, "R5 new key hits");
        look(20'h00007, 1'b1, 20'h00009, "R6 hit refreshes");
        chk_repl(2'd2, "R6 pointer after hit");
        fill(20'h00009, 20'h0000F);
        chk_repl(2'd3, "R9 in-place update keeps slots");
        look(20'h00009, 1'b1, 20'h0000F, "R9 updated ppn");
        look(20'h0000B, 1'b1, 20'h00003, "R9 other entry intact");
        op(1'b0, '0, 1'b0, '0, "", 1'b0, '0, '0, 1'b1, 20'h00007, 1'b0);
        look(20'h00007, 1'b0, '0, "R8 invalidated key misses");
        look(20'h0000D, 1'b1, 20'h0000A, "R8 neighbour kept");
        chk_repl(2'd1, "R4 hole refilled first");
        op(1'b0, '0, 1'b0, '0, "", 1'b0, '0, '0, 1'b1, 20'h00055, 1'b0);
        look(20'h00009, 1'b1, 20'h0000F, "R8 unmatched invalidate no effect");
        look(20'h0000B, 1'b1, 20'h00003, "R8 unmatched invalidate no effect");
        chk_repl(2'd1, "R8 pointer unchanged");
        op(1'b0, '0, 1'b0, '0, "", 1'b1, 20'h00011, 20'h00022, 1'b0, '0, 1'b1);
        look(20'h00011, 1'b0, '0, "R10 fill dropped under flush");
        look(20'h0000D, 1'b0, '0, "R7 flush cleared");
        look(20'h00009, 1'b0, '0, "R7 flush cleared");
        chk_repl(2'd0, "R7 pointer after flush");
        fill(20'h0000D, 20'h0000A);
        look(20'h0000D, 1'b1, 20'h0000A, "R4 refill after flush");
        chk_repl(2'd1, "R4 pointer after refill");
        op(1'b0, '0, 1'b0, '0, "", 1'b0, '0, '0, 1'b0, '0, 1'b1);
        look(20'h0000D, 1'b0, '0, "R7 plain flush");
        repeat (2) @(posedge clk);
        if (exp_hit_q.size() != 0) begin
            failures++;
            $display("FAIL R1 scoreboard left %0d items, expected 0", exp_hit_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule